// File: doc/BRIEF.md
# Signed Compare Flag Generator

This block compares a register value with an operand and produces the three condition bits that a compare instruction leaves behind: a carry flag, an equal flag and a signed less-than flag. The register itself is never written. The caller picks either a full 32-bit compare or a 16-bit compare. In the 16-bit compare, the half register is the upper half of the register input. The 16-bit operand is the low half of the operand input for a memory operand, or its upper half for an immediate.

Compare requests enter on a valid/ready stream. They carry the register value, the operand, the width and source selects, and the current condition-key word. Results leave on a second valid/ready stream one register stage later. Each result holds the three flags, and the key word with the three compare bits replaced and every other bit copied unchanged. A constant clear-mask output tells the key logic which bits a compare owns.

Back-pressure rules:
- The input is ready whenever the output stage is empty or its result is being taken in the same cycle.
- A result that is offered and not taken stays unchanged until it is accepted.

Top module: `cmp_flag_unit`

## Requirements
- R1: `clr_mask` is the key word with only bits 13, 7 and 6 set (octal 020300). These are the bits a compare replaces.
- R2: `res_l` is the carry out of reg + ~operand + 1 at the selected width. It is 1 exactly when reg is greater than or equal to the operand as unsigned numbers, that is, when no borrow occurs.
- R3: `res_eq` is 1 exactly when the compared register value and operand are identical at the selected width.
- R4: `res_lt` is 1 exactly when the values differ and reg is less than the operand as two's-complement numbers. `res_eq` and `res_lt` are never both 1.
- R5: With `in_half`=1 the compare is 16-bit. The register value is `in_reg[31:16]`. The operand is `in_opnd[31:16]` when `in_imm`=1 and `in_opnd[15:0]` when `in_imm`=0. With `in_half`=0, all 32 bits are compared and `in_imm` has no effect.
- R6: `res_keys` bit 13 = `res_l`, bit 7 = `res_lt`, bit 6 = `res_eq`. Every other bit equals the `in_keys` bit of the same request.
- R7: `in_ready` = !`res_valid` || `res_ready`. A request accepted at a clock edge is presented on the result port right after that edge.
- R8: While `res_valid`=1 and `res_ready`=0, all result outputs hold their values.
- R9: After reset, `res_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_half | input | 1 | 1 = 16-bit compare, 0 = 32-bit |
| in_imm | input | 1 | 1 = operand is an immediate (16-bit form takes upper half) |
| in_reg | input | 32 | Register value |
| in_opnd | input | 32 | Operand value |
| in_keys | input | 16 | Current condition-key word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted when high with res_valid |
| res_l | output | 1 | Carry (no borrow) flag |
| res_eq | output | 1 | Equal flag |
| res_lt | output | 1 | Signed less-than flag |
| res_keys | output | 16 | Key word with compare bits replaced |
| clr_mask | output | 16 | Bits a compare clears and rewrites |

## Verification
The bench builds the block with its default widths: a 32-bit word, a 16-bit half and a 16-bit key word. At these widths, both the sign-boundary cases (0x80000000 against 1, 0x8000 against 0x7FFF) and all-ones operands are directly reachable. Directed cases cover equal values, mixed signs and garbage in the unused halves, followed by a random stream. The result port runs under a pseudo-random ready pattern, so stalls and same-cycle accept-and-refill both occur.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;
  localparam int KEY_W      = 16;
  localparam int KEY_BIT_L  = 13;
  localparam int KEY_BIT_LT = 7;
  localparam int KEY_BIT_EQ = 6;

  typedef struct packed {
    logic l;
    logic eq;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/cmp_operand_select.sv
module cmp_operand_select #(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic [WORD_W-1:0] reg_val,
  input  logic [WORD_W-1:0] opnd_val,
  input  logic              use_imm,
  output logic [WORD_W-1:0] wide_a,
  output logic [WORD_W-1:0] wide_b,
  output logic [HALF_W-1:0] half_a,
  output logic [HALF_W-1:0] half_b
);
  always_comb begin
    wide_a = reg_val;
    wide_b = opnd_val;
    half_a = reg_val[WORD_W-1 -: HALF_W];
    half_b = use_imm ? opnd_val[WORD_W-1 -: HALF_W] : opnd_val[HALF_W-1:0];
  end
endmodule

// File: rtl/cmp_flag_core.sv
module cmp_flag_core
  import cmp_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);
  logic [W:0] diff;

  always_comb begin
    diff     = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    flags.l  = diff[W];
    flags.eq = (a == b);
    flags.lt = !flags.eq && ($signed(a) < $signed(b));
  end

  // Equal values never borrow (R2, R3)
  always_comb begin
    if (flags.eq) assert_eq_no_borrow_R2: assert (flags.l);
  end

  // Same-sign operands: signed less-than implies a borrow (R4, R2)
  always_comb begin
    if (flags.lt && (a[W-1] == b[W-1])) assert_lt_borrow_R4: assert (!flags.l);
  end
endmodule

// File: rtl/cmp_key_merge.sv
module cmp_key_merge
  import cmp_flag_pkg::*;
#(
  parameter int KW = KEY_W
) (
  input  logic [KW-1:0] keys_in,
  input  cmp_flags_t    flags,
  output logic [KW-1:0] keys_out,
  output logic [KW-1:0] mask
);
  localparam logic [KW-1:0] OWN_MASK =
      (KW'(1) << KEY_BIT_L) | (KW'(1) << KEY_BIT_LT) | (KW'(1) << KEY_BIT_EQ);

  always_comb begin
    mask                 = OWN_MASK;
    keys_out             = keys_in & ~OWN_MASK;
    keys_out[KEY_BIT_L]  = flags.l;
    keys_out[KEY_BIT_LT] = flags.lt;
    keys_out[KEY_BIT_EQ] = flags.eq;
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = WORD_W / 2,
  parameter int KW     = KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_half,
  input  logic              in_imm,
  input  logic [WORD_W-1:0] in_reg,
  input  logic [WORD_W-1:0] in_opnd,
  input  logic [KW-1:0]     in_keys,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_l,
  output logic              res_eq,
  output logic              res_lt,
  output logic [KW-1:0]     res_keys,
  output logic [KW-1:0]     clr_mask
);
  logic [WORD_W-1:0] wide_a, wide_b;
  logic [HALF_W-1:0] half_a, half_b;
  cmp_flags_t        wide_f, half_f, sel_f, held_f;
  logic [KW-1:0]     merged_keys, held_keys;
  logic              accept;

  cmp_operand_select #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_sel (
    .reg_val (in_reg),
    .opnd_val(in_opnd),
    .use_imm (in_imm),
    .wide_a  (wide_a),
    .wide_b  (wide_b),
    .half_a  (half_a),
    .half_b  (half_b)
  );

  cmp_flag_core #(.W(WORD_W)) u_wide (.a(wide_a), .b(wide_b), .flags(wide_f));
  cmp_flag_core #(.W(HALF_W)) u_half (.a(half_a), .b(half_b), .flags(half_f));

  assign sel_f = in_half ? half_f : wide_f;

  cmp_key_merge #(.KW(KW)) u_merge (
    .keys_in (in_keys),
    .flags   (sel_f),
    .keys_out(merged_keys),
    .mask    (clr_mask)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      held_f    <= '0;
      held_keys <= '0;
    end else begin
      if (accept) begin
        res_valid <= 1'b1;
        held_f    <= sel_f;
        held_keys <= merged_keys;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign res_l    = held_f.l;
  assign res_eq   = held_f.eq;
  assign res_lt   = held_f.lt;
  assign res_keys = held_keys;

  assert_eq_lt_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_eq && res_lt));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_keys) && $stable(res_l)
                                   && $stable(res_eq) && $stable(res_lt)));

  assert_accept_presents_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  assert_empty_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> in_ready);
endmodule

// File: tb/cmp_flag_unit_test.sv
module cmp_flag_unit_test;
  typedef struct {
    logic        l, eq, lt;
    logic [15:0] keys;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_half = 0, in_imm = 0, res_ready = 0;
  logic [31:0] in_reg = 0, in_opnd = 0;
  logic [15:0] in_keys = 0;
  logic        in_ready, res_valid, res_l, res_eq, res_lt;
  logic [15:0] res_keys, clr_mask;
  int          checks = 0, errors = 0;
  bit          done = 0;
  exp_t        sb[$];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  cmp_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_half(in_half), .in_imm(in_imm), .in_reg(in_reg), .in_opnd(in_opnd),
    .in_keys(in_keys), .res_valid(res_valid), .res_ready(res_ready),
    .res_l(res_l), .res_eq(res_eq), .res_lt(res_lt), .res_keys(res_keys),
    .clr_mask(clr_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t model(bit half, bit imm, logic [31:0] r, logic [31:0] o, logic [15:0] k);
    exp_t e;
    if (half) begin
      logic [15:0] a, b;
      a = r[31:16];
      b = imm ? o[31:16] : o[15:0];
      e.l = a >= b; e.eq = a == b; e.lt = (a != b) && ($signed(a) < $signed(b));
    end else begin
      e.l = r >= o; e.eq = r == o; e.lt = (r != o) && ($signed(r) < $signed(o));
    end
    e.keys = k;
    e.keys[13] = e.l; e.keys[7] = e.lt; e.keys[6] = e.eq;
    return e;
  endfunction

  task automatic send(input bit half, input bit imm, input logic [31:0] r, input logic [31:0] o, input logic [15:0] k);
    @(negedge clk);
    in_valid = 1; in_half = half; in_imm = imm; in_reg = r; in_opnd = o; in_keys = k;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    sb.push_back(model(half, imm, r, o, k));
    @(negedge clk);
    in_valid = 0;
  endtask

  // ready pattern, changes away from sampling point
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    res_ready = rst_n && (lfsr[1:0] != 2'b00);
  end

  // monitor
  logic        was_stall = 0;
  logic [18:0] snap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stall)
        chk(res_valid && {res_l, res_eq, res_lt, res_keys} == snap, "R8 stall hold",
            {res_l, res_eq, res_lt, res_keys}, snap);
      chk(in_ready == (!res_valid || res_ready), "R7 ready rule", in_ready, !res_valid || res_ready);
      chk(clr_mask == 16'o020300, "R1 clear mask", clr_mask, 16'o020300);
      if (res_valid) chk(!(res_eq && res_lt), "R4 exclusive", {res_eq, res_lt}, 0);
      if (res_valid && res_ready) begin
        if (sb.size() == 0) chk(0, "R7 unexpected result", res_keys, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(res_l == e.l, "R2 carry flag", res_l, e.l);
          chk(res_eq == e.eq, "R3 equal flag", res_eq, e.eq);
          chk(res_lt == e.lt, "R4 less-than flag", res_lt, e.lt);
          chk(res_keys == e.keys, "R6 R5 key word", res_keys, e.keys);
        end
      end
      was_stall = res_valid && !res_ready;
      snap = {res_l, res_eq, res_lt, res_keys};
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R9 reset valid", res_valid, 0);
    chk(in_ready == 1, "R9 reset ready", in_ready, 1);
    rst_n = 1;
    // directed cases
    send(0, 0, 32'h1234_5678, 32'h1234_5678, 16'hFFFF);  // R3 equal, R6 passthrough ones
    send(0, 0, 32'h0000_0005, 32'h0000_0003, 16'h0000);  // R2 no borrow
    send(0, 0, 32'h0000_0003, 32'h0000_0005, 16'h0000);  // R4 lt with borrow
    send(0, 0, 32'h8000_0000, 32'h0000_0001, 16'h1234);  // R4 negative vs positive, R2 carry
    send(0, 0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h5A5A);  // R4 positive vs -1
    send(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0F0F);  // R5 imm ignored in wide form
    send(1, 0, 32'h8000_1111, 32'h2222_7FFF, 16'hA5A5);  // R5 half memory operand
    send(1, 1, 32'h8000_1111, 32'h7FFF_2222, 16'hA5A5);  // R5 half immediate operand
    send(1, 0, 32'h4321_0000, 32'hFFFF_4321, 16'h0000);  // R5 R3 half equal, upper garbage
    send(1, 1, 32'h4321_9999, 32'h4321_0000, 16'h0000);  // R5 half imm equal
    send(1, 0, 32'hFFFF_0000, 32'h0000_0000, 16'hFFFF);  // R4 -1 vs 0 half
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r, o;
      r = $urandom; o = ($urandom % 4 == 0) ? r : $urandom;
      send($urandom % 2, $urandom % 2, r, o, $urandom);
    end
    repeat (40) @(negedge clk);
    chk(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule